// File: doc/BRIEF.md
# Serial Memory Slave Command Front-End

This block is the serial slave side of a small byte-wide memory. A bus master selects it with an active-low chip-select and clocks bits in on `mosi`, most significant bit first. Each transfer starts with a one-byte opcode. The block decodes the opcode and collects the address that follows. For reads, it streams bytes out of an internal array on `miso`, and the address counter steps forward after each byte.

Latch and status-register commands are passed to a neighbouring status block as one-cycle strobes. Array writes are passed to a neighbouring write sequencer as one strobe per byte, followed by a commit strobe. The sequencer programs the internal array through a plain write port.

All four bus pins are synchronized into the fast system clock, and clock edges are detected there; the block has no second clock domain. Bus modes 0 and 3 both work: `sck` may idle low or high. A hold input pauses a transfer without losing any bit already shifted in. Unknown opcodes make the slave ignore the rest of the transfer.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `miso_oe` is 0. After reset, no command is accepted until `cs_n` has gone from high to low; a chip-select held low through reset is ignored.
- R2: Bits are taken on rising `sck` edges, most significant bit first, in bus mode 0 (idle low) and mode 3 (idle high). An opcode is valid only when bits 7..4 are zero and bits 2..0 are one of these: 110 set-latch, 100 clear-latch, 101 status read, 001 status write, 011 array read, 010 array write. Bit 3 is ignored, except in reads and writes, where it is address bit 8.
- R3: A set-latch or clear-latch opcode gives exactly one pulse on `setwe_o` or `clrwe_o` when its 8th bit arrives. After that, every clock is ignored until `cs_n` rises.
- R4: A status read drives `stat_i`, captured at the 8th rising edge, MSB first on `miso` with `miso_oe` high. Bits change after falling edges. After the byte, `miso_oe` returns to 0 until deselection.
- R5: An array read takes an address byte; the full address is {opcode bit 3, address byte}, cut to ADDR_W bits. From the falling edge after the 16th rising edge, the byte at that address goes out MSB first. The address then increments for each further byte, and wraps from the top location to 0.
- R6: If `busy_i` is 1 when an array-read opcode completes, the read is rejected: `miso_oe` stays 0 for the rest of the transfer.
- R7: An invalid opcode (nonzero bits 7..4, or bits 2..0 equal to 000 or 111) makes the slave ignore everything until `cs_n` rises. No strobe is produced.
- R8: A status write gives one `stwr_o` pulse, with the received byte on `stwr_data_o`. This happens only when `cs_n` rises after exactly 16 rising edges. A 17th rising edge cancels it.
- R9: An array write gives one `wbyte_o` pulse per complete data byte, with its address and data. The address increments within a 16-byte page: the low 4 bits wrap and the upper bits are kept. `commit_o` pulses when `cs_n` rises on a byte boundary after at least one data byte. A rise in the middle of a byte gives no commit.
- R10: Hold starts when `hold_n` is low while `sck` is low and the slave is selected. During hold, `miso_oe` is 0 and `sck`/`mosi` are ignored. Hold ends when `hold_n` is high while `sck` is low, and the transfer then continues with no bit lost.
- R11: Raising `cs_n` during hold aborts the transfer. A new transfer needs `hold_n` high and a new falling `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus chip-select, active low |
| sck | input | 1 | Bus serial clock |
| mosi | input | 1 | Bus serial data into the slave |
| hold_n | input | 1 | Pause request, active low |
| busy_i | input | 1 | Write cycle in progress, from the write sequencer |
| stat_i | input | 8 | Status byte returned by a status read |
| mem_we_i | input | 1 | Array write enable from the write sequencer |
| mem_waddr_i | input | ADDR_W | Array write address |
| mem_wdata_i | input | 8 | Array write data |
| miso | output | 1 | Bus serial data out of the slave |
| miso_oe | output | 1 | Output enable for `miso` (pin is high impedance when 0) |
| setwe_o | output | 1 | Set-latch strobe |
| clrwe_o | output | 1 | Clear-latch strobe |
| stwr_o | output | 1 | Status write strobe |
| stwr_data_o | output | 8 | Status byte received |
| wbyte_o | output | 1 | Array write data-byte strobe |
| wbyte_addr_o | output | ADDR_W | Address of the strobed byte |
| wbyte_data_o | output | 8 | Data of the strobed byte |
| commit_o | output | 1 | Start of the write cycle |

## Verification
The bench targets these corner cases:

- **Read wrap.** A read running past the top address must wrap to 0. A design that saturated there, or dropped bit 8 taken from the opcode, would return wrong bytes.
- **Write page wrap.** A write crossing a page end must give addresses that wrap inside the page, not into the next page.
- **Hold mid-byte.** A hold is applied in the middle of a data byte and junk clocks are sent during it. A design that counted those clocks, or kept driving `miso`, would corrupt or shift the byte.
- **Cancellation rules.** A status write is followed by a 17th edge, an array write ends mid-byte, an invalid opcode is followed by a valid-looking one, a read is sent while busy, and chip-select is held low through reset. Each of these must produce no strobe or no output.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_RDAT,
    ST_SOUT,
    ST_SIN,
    ST_SARM,
    ST_WDAT,
    ST_WAIT
  } fe_state_t;

  localparam logic [2:0] OPL_SETWE = 3'b110;
  localparam logic [2:0] OPL_CLRWE = 3'b100;
  localparam logic [2:0] OPL_STRD  = 3'b101;
  localparam logic [2:0] OPL_STWR  = 3'b001;
  localparam logic [2:0] OPL_READ  = 3'b011;
  localparam logic [2:0] OPL_WRITE = 3'b010;

  function automatic logic op_valid(input logic [7:0] b);
    return (b[7:4] == 4'd0) && (b[2:0] != 3'b000) && (b[2:0] != 3'b111);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int            N       = 4,
  parameter int            STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);

  logic [STAGES-1:0][N-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic hold_o
);

  logic hold_q, hold_nx;

  always_comb begin
    hold_nx = hold_q;
    if (!sck_i) hold_nx = !hold_n_i && (sel_i || hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_nx;
  end

  assign hold_o = hold_q;

  // R10: hold is entered only from a clock-low sample
  p_hold_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!sck_i && !hold_n_i));

  // R10: hold is left only with hold_n high while the clock is low
  p_hold_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(!sck_i && hold_n_i));

endmodule

// File: rtl/spi_rd_array.sv
module spi_rd_array #(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic              hold_i,
  input  logic              busy_i,
  input  logic [7:0]        stat_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              oe_o,
  output logic              miso_o,
  output logic              setwe_o,
  output logic              clrwe_o,
  output logic              stwr_o,
  output logic [7:0]        stwr_data_o,
  output logic              wbyte_o,
  output logic [ADDR_W-1:0] wbyte_addr_o,
  output logic [7:0]        wbyte_data_o,
  output logic              commit_o
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  fe_state_t         state_q, state_nx;
  logic [2:0]        cnt_q, cnt_nx;
  logic [6:0]        sh_q, sh_nx;
  logic [7:0]        tx_q, tx_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              a8_q, a8_nx;
  logic              wr_q, wr_nx;
  logic              ld_q, ld_nx;
  logic              got_q, got_nx;
  logic              miso_q, miso_nx;
  logic              oe_q, oe_nx;
  logic              setwe_q, setwe_nx;
  logic              clrwe_q, clrwe_nx;
  logic              stwr_q, stwr_nx;
  logic [7:0]        sdat_q, sdat_nx;
  logic              wb_q, wb_nx;
  logic [ADDR_W-1:0] wba_q, wba_nx;
  logic [7:0]        wbd_q, wbd_nx;
  logic              cmt_q, cmt_nx;

  logic              rise_g, fall_g, last;
  logic [7:0]        byte_w;
  logic [8:0]        full_addr;
  logic [ADDR_W-1:0] addr_load, page_inc;

  assign rise_g    = sck_rise_i && !hold_i;
  assign fall_g    = sck_fall_i && !hold_i;
  assign byte_w    = {sh_q, mosi_i};
  assign last      = (cnt_q == 3'd7);
  assign full_addr = {a8_q, byte_w};
  assign addr_load = full_addr[ADDR_W-1:0];
  assign page_inc  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_ONE};

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    sh_nx    = sh_q;
    tx_nx    = tx_q;
    addr_nx  = addr_q;
    a8_nx    = a8_q;
    wr_nx    = wr_q;
    ld_nx    = ld_q;
    got_nx   = got_q;
    miso_nx  = miso_q;
    sdat_nx  = sdat_q;
    wba_nx   = wba_q;
    wbd_nx   = wbd_q;
    setwe_nx = 1'b0;
    clrwe_nx = 1'b0;
    stwr_nx  = 1'b0;
    wb_nx    = 1'b0;
    cmt_nx   = 1'b0;
    if (cs_rise_i) begin
      if (state_q == ST_SARM) stwr_nx = 1'b1;
      if (state_q == ST_WDAT && cnt_q == 3'd0 && got_q) cmt_nx = 1'b1;
      state_nx = ST_IDLE;
      ld_nx    = 1'b0;
    end else if (cs_fall_i) begin
      state_nx = ST_CMD;
      cnt_nx   = 3'd0;
      got_nx   = 1'b0;
    end else begin
      if (ld_q) begin
        tx_nx   = rd_data_i;
        addr_nx = addr_q + ADDR_ONE;
        ld_nx   = 1'b0;
      end
      if (rise_g && state_q != ST_IDLE && state_q != ST_WAIT) begin
        cnt_nx = cnt_q + 3'd1;
        sh_nx  = byte_w[6:0];
        unique case (state_q)
          ST_CMD: if (last) begin
            if (!op_valid(byte_w)) begin
              state_nx = ST_WAIT;
            end else begin
              unique case (byte_w[2:0])
                OPL_SETWE: begin setwe_nx = 1'b1; state_nx = ST_WAIT; end
                OPL_CLRWE: begin clrwe_nx = 1'b1; state_nx = ST_WAIT; end
                OPL_STRD:  begin tx_nx = stat_i; state_nx = ST_SOUT; end
                OPL_STWR:  state_nx = ST_SIN;
                OPL_READ: begin
                  if (busy_i) state_nx = ST_WAIT;
                  else begin
                    a8_nx    = byte_w[3];
                    wr_nx    = 1'b0;
                    state_nx = ST_ADDR;
                  end
                end
                OPL_WRITE: begin
                  a8_nx    = byte_w[3];
                  wr_nx    = 1'b1;
                  state_nx = ST_ADDR;
                end
                default: state_nx = ST_WAIT;
              endcase
            end
          end
          ST_ADDR: if (last) begin
            addr_nx = addr_load;
            if (wr_q) state_nx = ST_WDAT;
            else begin
              ld_nx    = 1'b1;
              state_nx = ST_RDAT;
            end
          end
          ST_RDAT: if (last) ld_nx = 1'b1;
          ST_SOUT: if (last) state_nx = ST_WAIT;
          ST_SIN: if (last) begin
            sdat_nx  = byte_w;
            state_nx = ST_SARM;
          end
          ST_SARM: state_nx = ST_WAIT;
          ST_WDAT: if (last) begin
            wb_nx   = 1'b1;
            wbd_nx  = byte_w;
            wba_nx  = addr_q;
            addr_nx = page_inc;
            got_nx  = 1'b1;
          end
          default: ;
        endcase
      end
      if (fall_g && (state_q == ST_RDAT || state_q == ST_SOUT))
        miso_nx = tx_q[~cnt_q];
    end
    oe_nx = (state_nx == ST_RDAT) || (state_nx == ST_SOUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      sh_q    <= 7'd0;
      tx_q    <= 8'd0;
      addr_q  <= '0;
      a8_q    <= 1'b0;
      wr_q    <= 1'b0;
      ld_q    <= 1'b0;
      got_q   <= 1'b0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
      setwe_q <= 1'b0;
      clrwe_q <= 1'b0;
      stwr_q  <= 1'b0;
      sdat_q  <= 8'd0;
      wb_q    <= 1'b0;
      wba_q   <= '0;
      wbd_q   <= 8'd0;
      cmt_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      sh_q    <= sh_nx;
      tx_q    <= tx_nx;
      addr_q  <= addr_nx;
      a8_q    <= a8_nx;
      wr_q    <= wr_nx;
      ld_q    <= ld_nx;
      got_q   <= got_nx;
      miso_q  <= miso_nx;
      oe_q    <= oe_nx;
      setwe_q <= setwe_nx;
      clrwe_q <= clrwe_nx;
      stwr_q  <= stwr_nx;
      sdat_q  <= sdat_nx;
      wb_q    <= wb_nx;
      wba_q   <= wba_nx;
      wbd_q   <= wbd_nx;
      cmt_q   <= cmt_nx;
    end
  end

  assign addr_o       = addr_q;
  assign sel_o        = (state_q != ST_IDLE);
  assign oe_o         = oe_q;
  assign miso_o       = miso_q;
  assign setwe_o      = setwe_q;
  assign clrwe_o      = clrwe_q;
  assign stwr_o       = stwr_q;
  assign stwr_data_o  = sdat_q;
  assign wbyte_o      = wb_q;
  assign wbyte_addr_o = wba_q;
  assign wbyte_data_o = wbd_q;
  assign commit_o     = cmt_q;

  // R1: a deselect always lands in idle with the output released
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> (state_q == ST_IDLE && !oe_q));

  // R3: the wait state holds until chip-select rises
  p_wait_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !cs_rise_i) |=> (state_q == ST_WAIT));

  // R3: at most one strobe per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({setwe_q, clrwe_q, stwr_q, wb_q, cmt_q}));

  // R5: every array fetch steps the read address by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !cs_rise_i) |=> (addr_q == $past(addr_q) + ADDR_ONE));

  // R6: a read opcode while busy goes straight to the wait state
  p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && rise_g && last && busy_i && !cs_rise_i &&
     byte_w[7:4] == 4'd0 && byte_w[2:0] == OPL_READ) |=> (state_q == ST_WAIT));

  // R10: clock edges during hold leave the shift state untouched
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !cs_rise_i && !cs_fall_i) |=> ($stable(cnt_q) && $stable(sh_q)));

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              hold_n,
  input  logic              busy_i,
  input  logic [7:0]        stat_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_waddr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic              miso,
  output logic              miso_oe,
  output logic              setwe_o,
  output logic              clrwe_o,
  output logic              stwr_o,
  output logic [7:0]        stwr_data_o,
  output logic              wbyte_o,
  output logic [ADDR_W-1:0] wbyte_addr_o,
  output logic [7:0]        wbyte_data_o,
  output logic              commit_o
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // pin order: hold_n, mosi, sck, cs_n; chip-select resets to "low" so a
  // select held through reset never makes a falling edge
  logic [3:0] pins_s;
  logic       cs_s, sck_s, mosi_s, hold_s;
  logic [1:0] edge_prev_q;

  spi_pin_sync #(
    .N       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1000)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .pin_i  ({hold_n, mosi, sck, cs_n}),
    .sync_o (pins_s)
  );

  assign {hold_s, mosi_s, sck_s, cs_s} = pins_s;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) edge_prev_q <= 2'b00;
    else         edge_prev_q <= {sck_s, cs_s};
  end

  logic cs_rise, cs_fall, sck_rise, sck_fall;
  assign cs_rise  =  cs_s  & ~edge_prev_q[0];
  assign cs_fall  = ~cs_s  &  edge_prev_q[0];
  assign sck_rise =  sck_s & ~edge_prev_q[1];
  assign sck_fall = ~sck_s &  edge_prev_q[1];

  logic              sel, hold_act, oe_raw;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  spi_hold_ctl u_hold (
    .clk      (clk),
    .rst_n    (rst_ni),
    .sel_i    (sel),
    .sck_i    (sck_s),
    .hold_n_i (hold_s),
    .hold_o   (hold_act)
  );

  spi_cmd_fsm #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_ni),
    .cs_rise_i    (cs_rise),
    .cs_fall_i    (cs_fall),
    .sck_rise_i   (sck_rise),
    .sck_fall_i   (sck_fall),
    .mosi_i       (mosi_s),
    .hold_i       (hold_act),
    .busy_i       (busy_i),
    .stat_i       (stat_i),
    .rd_data_i    (rd_data),
    .addr_o       (rd_addr),
    .sel_o        (sel),
    .oe_o         (oe_raw),
    .miso_o       (miso),
    .setwe_o      (setwe_o),
    .clrwe_o      (clrwe_o),
    .stwr_o       (stwr_o),
    .stwr_data_o  (stwr_data_o),
    .wbyte_o      (wbyte_o),
    .wbyte_addr_o (wbyte_addr_o),
    .wbyte_data_o (wbyte_data_o),
    .commit_o     (commit_o)
  );

  spi_rd_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk     (clk),
    .we_i    (mem_we_i),
    .waddr_i (mem_waddr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign miso_oe = oe_raw & ~hold_act;

endmodule

// File: tb/spi_mem_front_tb_top.sv
`timescale 1ns/1ps
module spi_mem_front_tb_top;

  localparam int HP = 8;

  logic clk, rst_n;
  logic cs_n, sck, mosi, hold_n, busy;
  logic [7:0] stat;
  logic mem_we;
  logic [8:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic miso, miso_oe, setwe, clrwe, stwr, wbyte, commit;
  logic [7:0] stwr_data, wbyte_data;
  logic [8:0] wbyte_addr;

  spi_mem_front dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .busy_i(busy), .stat_i(stat), .mem_we_i(mem_we),
    .mem_waddr_i(mem_waddr), .mem_wdata_i(mem_wdata), .miso(miso),
    .miso_oe(miso_oe), .setwe_o(setwe), .clrwe_o(clrwe), .stwr_o(stwr),
    .stwr_data_o(stwr_data), .wbyte_o(wbyte), .wbyte_addr_o(wbyte_addr),
    .wbyte_data_o(wbyte_data), .commit_o(commit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int n_set = 0, n_clr = 0, n_stwr = 0, n_cmt = 0, n_wb = 0;
  logic [7:0] last_stwr;
  logic [8:0] wb_a [32];
  logic [7:0] wb_d [32];
  logic [7:0] model [512];
  bit mode3 = 1'b0;

  always @(posedge clk) begin
    if (setwe)  n_set++;
    if (clrwe)  n_clr++;
    if (stwr) begin n_stwr++; last_stwr = stwr_data; end
    if (commit) n_cmt++;
    if (wbyte) begin
      wb_a[n_wb % 32] = wbyte_addr;
      wb_d[n_wb % 32] = wbyte_data;
      n_wb++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    sck = 1'b0; mosi = b;
    wclk(HP);
    r = miso; oe = miso_oe;
    sck = 1'b1;
    wclk(HP);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_all, output logic oe_any);
    logic r, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic sel();
    sck = mode3; wclk(HP);
    cs_n = 1'b0; wclk(HP);
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    wclk(HP);
    cs_n = 1'b1; wclk(2*HP);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] rx; logic a, y;
    byte_x(b, rx, a, y);
  endtask

  task automatic read_chk(input logic [8:0] a, input int len, input string tag);
    logic [7:0] rx; logic oa, oy;
    sel();
    send({4'b0000, a[8], 3'b011});
    send(a[7:0]);
    for (int i = 0; i < len; i++) begin
      byte_x(8'h00, rx, oa, oy);
      chk(tag, rx, model[(a + i) % 512]);
      chk({tag, " oe"}, oa, 1);
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx, sv; logic oa, oy, r, oe;
    int s0, c0, w0, k0;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1;
    busy = 1'b0; stat = 8'h00; mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    wclk(10);
    rst_n = 1'b1;
    wclk(6);
    chk("R1 reset oe", miso_oe, 0);
    // R1: select held through reset: a set-latch frame must be ignored
    send(8'h06);
    sck = 1'b0; wclk(HP);
    chk("R1 no fall after reset", n_set, 0);
    cs_n = 1'b1; wclk(2*HP);
    chk("R1 deselected oe", miso_oe, 0);

    for (int a = 0; a < 512; a++) begin
      model[a] = 8'($urandom);
      mem_we = 1'b1; mem_waddr = 9'(a); mem_wdata = model[a];
      wclk(1);
    end
    mem_we = 1'b0;
    wclk(2);

    // R3 latch strobes
    sel(); send(8'h06); desel();
    chk("R3 set strobe", n_set, 1);
    sel(); send(8'h06); send(8'h04); desel();
    chk("R3 set once", n_set, 2);
    chk("R3 clear ignored after set", n_clr, 0);
    sel(); send(8'h0E); desel();
    chk("R2 bit3 ignored on set", n_set, 3);
    sel(); send(8'h04); desel();
    chk("R3 clear strobe", n_clr, 1);

    // R7 invalid opcodes
    sel(); send(8'h07); send(8'h06); desel();
    sel(); send(8'h86); send(8'h06); desel();
    sel(); send(8'h00); send(8'h04); desel();
    chk("R7 invalid set", n_set, 3);
    chk("R7 invalid clear", n_clr, 1);

    // R4 status read
    stat = 8'($urandom);
    sel(); send(8'h05);
    byte_x(8'h00, rx, oa, oy);
    chk("R4 status byte", rx, stat);
    chk("R4 status oe", oa, 1);
    byte_x(8'h00, rx, oa, oy);
    chk("R4 oe after byte", oy, 0);
    desel();

    // R8 status write
    sv = 8'($urandom);
    sel(); send(8'h01); send(sv); desel();
    chk("R8 status write strobe", n_stwr, 1);
    chk("R8 status data", last_stwr, sv);
    sel(); send(8'h01); send(~sv); bit_x(1'b0, r, oe); desel();
    chk("R8 17th edge cancels", n_stwr, 1);

    // R9 array write with page wrap
    w0 = n_wb; k0 = n_cmt;
    sel(); send(8'h0A); send(8'hFE); send(8'h11); send(8'h22); send(8'h33); desel();
    chk("R9 byte strobes", n_wb - w0, 3);
    chk("R9 addr0", wb_a[w0 % 32], 9'h1FE);
    chk("R9 addr1", wb_a[(w0+1) % 32], 9'h1FF);
    chk("R9 page wrap addr", wb_a[(w0+2) % 32], 9'h1F0);
    chk("R9 data2", wb_d[(w0+2) % 32], 8'h33);
    chk("R9 commit", n_cmt - k0, 1);
    w0 = n_wb; k0 = n_cmt;
    sel(); send(8'h02); send(8'h10); send(8'hA5); send(8'h5A);
    bit_x(1'b1, r, oe); bit_x(1'b0, r, oe); bit_x(1'b1, r, oe); desel();
    chk("R9 partial byte strobes", n_wb - w0, 2);
    chk("R9 partial addr", wb_a[(w0+1) % 32], 9'h011);
    chk("R9 no commit mid-byte", n_cmt - k0, 0);

    // R5 reads
    read_chk(9'h1FE, 4, "R5 read wrap");
    read_chk(9'h000, 2, "R5 read low");
    mode3 = 1'b1;
    read_chk(9'h0C3, 3, "R2 mode3 read");
    for (int t = 0; t < 16; t++) begin
      mode3 = 1'($urandom);
      read_chk(9'($urandom), 1 + int'($urandom % 4), "R5 random read");
    end
    mode3 = 1'b0;

    // R6 busy reject
    busy = 1'b1;
    sel(); send(8'h03); send(8'h20);
    byte_x(8'h00, rx, oa, oy); byte_x(8'h00, rx, oa, r);
    chk("R6 busy read rejected", oy | r, 0);
    desel();
    busy = 1'b0;

    // R10 hold in the middle of a data byte
    sel(); send(8'h0B); send(8'h40);
    for (int i = 7; i >= 4; i--) begin bit_x(1'b0, r, oe); rx[i] = r; end
    sck = 1'b0; wclk(HP);
    hold_n = 1'b0; wclk(HP);
    chk("R10 oe off in hold", miso_oe, 0);
    for (int j = 0; j < 3; j++) begin
      mosi = 1'b1; sck = 1'b1; wclk(HP); sck = 1'b0; wclk(HP);
    end
    chk("R10 oe off after junk clocks", miso_oe, 0);
    hold_n = 1'b1; wclk(HP);
    for (int i = 3; i >= 0; i--) begin bit_x(1'b0, r, oe); rx[i] = r; end
    chk("R10 byte across hold", rx, model[9'h140]);
    byte_x(8'h00, rx, oa, oy);
    chk("R10 next byte after hold", rx, model[9'h141]);
    desel();

    // R11 deselect during hold aborts
    s0 = n_set; c0 = n_clr;
    sel();
    for (int i = 0; i < 4; i++) bit_x(1'b0, r, oe);
    sck = 1'b0; wclk(HP);
    hold_n = 1'b0; wclk(HP);
    cs_n = 1'b1; wclk(2*HP);
    hold_n = 1'b1; wclk(HP);
    chk("R11 aborted frame silent", n_set - s0, 0);
    sel(); send(8'h06); desel();
    chk("R11 fresh frame after abort", n_set - s0, 1);
    chk("R11 no stray clear", n_clr - c0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule